// File: doc/BRIEF.md
# Vector Register Index Remapper

This block turns the register number that one wavefront uses for a vector operand into a physical address in a shared vector register file. Each wavefront owns one contiguous window of the file. The window is given by a start index and a count of reserved entries. Ordinary operands map straight into the window: start plus register number.

Wide operands get their own name space when the wide-mapping mode bit is set and the operand is larger than 4 bytes. That name space sits behind the single-precision registers of the window and uses a stride of two entries. The final address is taken modulo the size of the register file, so a window may run past the last entry and continue from entry zero.

A request is presented for one cycle with `req_valid_i`, and the answer appears one cycle later with `rsp_valid_o`. A request that breaks the window rules does not stop anything. It returns the error flag with address zero.

Top module: `vreg_remap`

## Requirements
- R1: `rsp_valid_o` is high in the cycle after each cycle in which `req_valid_i` is high, and low after each cycle in which it is low; back-to-back requests give back-to-back results.
- R2: With `dp_mode_i` = 0, the result is (`base_i` + `vidx_i`) modulo `file_size_i`.
- R3: With `dp_mode_i` = 1 and `opsize_i` greater than 4, the result is (`base_i` + `sp_count_i` + 2·`vidx_i`) modulo `file_size_i`.
- R4: With `dp_mode_i` = 1 and `opsize_i` of 4 or less, or with `dp_mode_i` = 0 and any size, the mapping of R2 applies.
- R5: A `reserved_i` of zero gives `err_o` = 1 and `pidx_o` = 0.
- R6: A `vidx_i` equal to or above `reserved_i` gives `err_o` = 1 and `pidx_o` = 0.
- R7: An offset from `base_i` that exceeds `reserved_i` − 1 gives `err_o` = 1 and `pidx_o` = 0, even when `vidx_i` is below `reserved_i`. Under R3 the offset is `sp_count_i` + 2·`vidx_i`; under R2 it is `vidx_i`.
- R8: An address past the end of the file wraps modulo `file_size_i`. This also holds when `base_i` itself lies beyond the file size.
- R9: A `file_size_i` of zero, or one above 2^`PIDX_W`, gives `err_o` = 1 and `pidx_o` = 0.
- R10: `pidx_o` and `err_o` keep their values in every cycle that follows a cycle with no request.
- R11: After reset, `rsp_valid_o`, `err_o` and `pidx_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| vidx_i | input | VIDX_W | Register number used by the wavefront |
| opsize_i | input | SIZE_W | Operand size in bytes |
| dp_mode_i | input | 1 | Selects the separate wide-operand name space |
| base_i | input | PIDX_W | First file entry of the window |
| reserved_i | input | PIDX_W+1 | Number of entries in the window |
| sp_count_i | input | PIDX_W+1 | Single-precision registers in the window |
| file_size_i | input | PIDX_W+1 | Number of entries in the register file |
| rsp_valid_o | output | 1 | Result strobe, one cycle after the request |
| pidx_o | output | PIDX_W | Physical file address |
| err_o | output | 1 | Window or file-size violation |

## Verification
Two situations are hard to reach from the ports.

The first is a wide operand whose register number is legal while its doubled offset plus the single-precision count runs off the end of the window. The stimulus walks `vidx_i` up to the last wide slot that fits, then one slot further, with `vidx_i` still below `reserved_i`.

The second is a modulo in which the sum exceeds the file size by more than one window. The stimulus places `base_i` beyond `file_size_i` and also places a window across the last entry. This exercises several subtract stages of the remainder chain in a single request.

// File: rtl/vreg_remap_pkg.sv
package vreg_remap_pkg;

  typedef enum logic {
    MAP_FLAT = 1'b0,
    MAP_WIDE = 1'b1
  } map_kind_e;

  // operands wider than this many bytes use the wide name space
  localparam int unsigned NARROW_BYTES = 4;

endpackage

// File: rtl/vreg_addr_calc.sv
module vreg_addr_calc
  import vreg_remap_pkg::*;
#(
  parameter int unsigned VIDX_W = 8,
  parameter int unsigned SIZE_W = 4,
  parameter int unsigned PIDX_W = 11,
  parameter int unsigned CNT_W  = PIDX_W + 1,
  parameter int unsigned SUM_W  = CNT_W + 3
) (
  input  logic [VIDX_W-1:0] vidx_i,
  input  logic [SIZE_W-1:0] opsize_i,
  input  logic              dp_mode_i,
  input  logic [PIDX_W-1:0] base_i,
  input  logic [CNT_W-1:0]  sp_count_i,
  output logic [SUM_W-1:0]  offs_o,
  output logic [SUM_W-1:0]  sum_o
);

  localparam logic [SIZE_W-1:0] NARROW_LIM = SIZE_W'(NARROW_BYTES);

  map_kind_e         kind;
  logic [SUM_W-1:0]  v_ext;
  logic [SUM_W-1:0]  sp_ext;
  logic [SUM_W-1:0]  base_ext;

  assign kind     = (dp_mode_i && (opsize_i > NARROW_LIM)) ? MAP_WIDE : MAP_FLAT;
  assign v_ext    = SUM_W'(vidx_i);
  assign sp_ext   = SUM_W'(sp_count_i);
  assign base_ext = SUM_W'(base_i);

  always_comb begin
    unique case (kind)
      MAP_WIDE: offs_o = sp_ext + (v_ext << 1);
      default:  offs_o = v_ext;
    endcase
  end

  assign sum_o = base_ext + offs_o;

endmodule

// File: rtl/vreg_bound_chk.sv
module vreg_bound_chk #(
  parameter int unsigned VIDX_W = 8,
  parameter int unsigned PIDX_W = 11,
  parameter int unsigned CNT_W  = PIDX_W + 1,
  parameter int unsigned SUM_W  = CNT_W + 3
) (
  input  logic [VIDX_W-1:0] vidx_i,
  input  logic [SUM_W-1:0]  offs_i,
  input  logic [CNT_W-1:0]  reserved_i,
  input  logic [CNT_W-1:0]  file_size_i,
  output logic              bad_o
);

  localparam int unsigned    CMP_W    = (VIDX_W > SUM_W) ? VIDX_W : SUM_W;
  localparam logic [CNT_W:0] FILE_MAX = (CNT_W+1)'(1) << PIDX_W;

  logic [CMP_W-1:0] v_c, o_c, r_c;
  logic             no_window, v_oob, o_oob, file_bad;

  assign v_c = CMP_W'(vidx_i);
  assign o_c = CMP_W'(offs_i);
  assign r_c = CMP_W'(reserved_i);

  assign no_window = (reserved_i == '0);
  assign v_oob     = (v_c >= r_c);
  // offset beyond last entry of the window
  assign o_oob     = (o_c >= r_c);
  assign file_bad  = (file_size_i == '0) || ({1'b0, file_size_i} > FILE_MAX);

  assign bad_o = no_window | v_oob | o_oob | file_bad;

endmodule

// File: rtl/vreg_mod_unit.sv
module vreg_mod_unit #(
  parameter int unsigned N_W = 15,
  parameter int unsigned D_W = 12
) (
  input  logic [N_W-1:0] num_i,
  input  logic [D_W-1:0] den_i,
  output logic [D_W-1:0] rem_o,
  output logic           spill_o
);

  // restoring remainder, one stage per dividend bit, msb first
  logic [D_W:0] rem [N_W+1];
  logic [N_W:0] spill;
  logic [D_W:0] den_x;

  assign den_x  = {1'b0, den_i};
  assign rem[0] = '0;

  for (genvar i = 0; i < N_W; i++) begin : g_stage
    logic [D_W:0] trial;
    logic         ge;
    assign spill[i] = rem[i][D_W];
    assign trial    = {rem[i][D_W-1:0], num_i[N_W-1-i]};
    assign ge       = (trial >= den_x);
    assign rem[i+1] = ge ? (trial - den_x) : trial;
  end

  assign spill[N_W] = rem[N_W][D_W];
  assign rem_o      = rem[N_W][D_W-1:0];
  assign spill_o    = |spill;

endmodule

// File: rtl/vreg_remap.sv
module vreg_remap #(
  parameter int unsigned VIDX_W = 8,
  parameter int unsigned SIZE_W = 4,
  parameter int unsigned PIDX_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [VIDX_W-1:0] vidx_i,
  input  logic [SIZE_W-1:0] opsize_i,
  input  logic              dp_mode_i,
  input  logic [PIDX_W-1:0] base_i,
  input  logic [PIDX_W:0]   reserved_i,
  input  logic [PIDX_W:0]   sp_count_i,
  input  logic [PIDX_W:0]   file_size_i,
  output logic              rsp_valid_o,
  output logic [PIDX_W-1:0] pidx_o,
  output logic              err_o
);

  localparam int unsigned CNT_W = PIDX_W + 1;
  localparam int unsigned SUM_W = ((CNT_W > VIDX_W + 1) ? CNT_W : VIDX_W + 1) + 3;

  logic [SUM_W-1:0] offs, sum;
  logic [CNT_W-1:0] rem;
  logic             bad, spill, hi_rem, fail;

  vreg_addr_calc #(
    .VIDX_W(VIDX_W), .SIZE_W(SIZE_W), .PIDX_W(PIDX_W),
    .CNT_W(CNT_W),   .SUM_W(SUM_W)
  ) u_calc (
    .vidx_i     (vidx_i),
    .opsize_i   (opsize_i),
    .dp_mode_i  (dp_mode_i),
    .base_i     (base_i),
    .sp_count_i (sp_count_i),
    .offs_o     (offs),
    .sum_o      (sum)
  );

  vreg_bound_chk #(
    .VIDX_W(VIDX_W), .PIDX_W(PIDX_W), .CNT_W(CNT_W), .SUM_W(SUM_W)
  ) u_bound (
    .vidx_i      (vidx_i),
    .offs_i      (offs),
    .reserved_i  (reserved_i),
    .file_size_i (file_size_i),
    .bad_o       (bad)
  );

  vreg_mod_unit #(
    .N_W(SUM_W), .D_W(CNT_W)
  ) u_mod (
    .num_i   (sum),
    .den_i   (file_size_i),
    .rem_o   (rem),
    .spill_o (spill)
  );

  // remainder beyond address width only if the file size check was bypassed
  assign hi_rem = |rem[CNT_W-1:PIDX_W];
  assign fail   = bad | spill | hi_rem;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      pidx_o      <= '0;
      err_o       <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        err_o  <= fail;
        pidx_o <= fail ? '0 : rem[PIDX_W-1:0];
      end
    end
  end

endmodule

// File: rtl/vreg_remap_chk.sv
module vreg_remap_chk #(
  parameter int unsigned VIDX_W = 8,
  parameter int unsigned PIDX_W = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [VIDX_W-1:0] vidx_i,
  input logic [PIDX_W:0]   reserved_i,
  input logic [PIDX_W:0]   file_size_i,
  input logic              rsp_valid_o,
  input logic [PIDX_W-1:0] pidx_o,
  input logic              err_o
);

  localparam int unsigned CMP_W = (VIDX_W > PIDX_W + 1) ? VIDX_W : PIDX_W + 1;

  assert_valid_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  assert_idle_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  assert_err_zero_addr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && err_o) |-> (pidx_o == '0));

  assert_no_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (reserved_i == '0)) |=> err_o);

  assert_vidx_oob_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (CMP_W'(vidx_i) >= CMP_W'(reserved_i))) |=> err_o);

  assert_in_file_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !err_o) |-> ({1'b0, pidx_o} < $past(file_size_i)));

  assert_zero_file_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (file_size_i == '0)) |=> err_o);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ($stable(pidx_o) && $stable(err_o)));

endmodule

bind vreg_remap vreg_remap_chk #(
  .VIDX_W(VIDX_W), .PIDX_W(PIDX_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .vidx_i      (vidx_i),
  .reserved_i  (reserved_i),
  .file_size_i (file_size_i),
  .rsp_valid_o (rsp_valid_o),
  .pidx_o      (pidx_o),
  .err_o       (err_o)
);

// File: tb/vreg_remap_bench.sv
`timescale 1ns/1ps
module vreg_remap_bench;

  localparam int unsigned VIDX_W = 8;
  localparam int unsigned SIZE_W = 4;
  localparam int unsigned PIDX_W = 11;
  localparam int          FMAX   = 1 << PIDX_W;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic [VIDX_W-1:0] vidx_i = '0;
  logic [SIZE_W-1:0] opsize_i = '0;
  logic              dp_mode_i = 1'b0;
  logic [PIDX_W-1:0] base_i = '0;
  logic [PIDX_W:0]   reserved_i = '0;
  logic [PIDX_W:0]   sp_count_i = '0;
  logic [PIDX_W:0]   file_size_i = '0;
  logic              rsp_valid_o;
  logic [PIDX_W-1:0] pidx_o;
  logic              err_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  vreg_remap #(.VIDX_W(VIDX_W), .SIZE_W(SIZE_W), .PIDX_W(PIDX_W)) u_vreg_remap (
    .clk_i, .rst_ni, .req_valid_i, .vidx_i, .opsize_i, .dp_mode_i, .base_i,
    .reserved_i, .sp_count_i, .file_size_i, .rsp_valid_o, .pidx_o, .err_o
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void model(input int v, sz, md, base, res, sp, fs,
                                output int e, output int p);
    int offs;
    offs = (md == 1 && sz > 4) ? sp + 2 * v : v;
    e = (res == 0 || v >= res || offs > res - 1 || fs == 0 || fs > FMAX) ? 1 : 0;
    p = (e != 0) ? 0 : (base + offs) % fs;
  endfunction

  task automatic drive(input int v, sz, md, base, res, sp, fs);
    vidx_i      = VIDX_W'(v);
    opsize_i    = SIZE_W'(sz);
    dp_mode_i   = md[0];
    base_i      = PIDX_W'(base);
    reserved_i  = (PIDX_W+1)'(res);
    sp_count_i  = (PIDX_W+1)'(sp);
    file_size_i = (PIDX_W+1)'(fs);
  endtask

  // one request; result checked at the following falling edge
  task automatic issue(input string tag, input int v, sz, md, base, res, sp, fs);
    int e, p;
    model(v, sz, md, base, res, sp, fs, e, p);
    @(negedge clk_i);
    drive(v, sz, md, base, res, sp, fs);
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk({tag, " valid"}, int'(rsp_valid_o), 1);
    chk({tag, " err"},   int'(err_o), e);
    chk({tag, " pidx"},  int'(pidx_o), p);
  endtask

  task automatic t_reset;
    chk("R11 valid", int'(rsp_valid_o), 0);
    chk("R11 err",   int'(err_o), 0);
    chk("R11 pidx",  int'(pidx_o), 0);
  endtask

  task automatic t_flat;
    issue("R2 base+5", 5, 4, 0, 100, 64, 32, 2048);
    issue("R2 last slot", 63, 2, 0, 100, 64, 32, 2048);
    @(negedge clk_i);
    chk("R1 idle low", int'(rsp_valid_o), 0);
  endtask

  task automatic t_mode_gate;
    issue("R4 dp size4", 5, 4, 1, 100, 64, 32, 2048);
    issue("R4 flat size8", 5, 8, 0, 100, 64, 32, 2048);
  endtask

  task automatic t_wide;
    issue("R3 wide v3", 3, 8, 1, 100, 64, 32, 2048);
    issue("R3 wide last", 15, 8, 1, 100, 64, 32, 2048);
    issue("R7 wide past window", 16, 8, 1, 100, 64, 32, 2048);
  endtask

  task automatic t_errors;
    issue("R5 no window", 0, 4, 0, 100, 0, 0, 2048);
    issue("R6 vidx eq reserved", 64, 4, 0, 100, 64, 32, 2048);
    issue("R9 zero file", 1, 4, 0, 10, 8, 0, 0);
    issue("R9 oversize file", 1, 4, 0, 10, 8, 0, 2049);
  endtask

  task automatic t_wrap;
    issue("R8 wrap end", 10, 4, 0, 2040, 16, 0, 2048);
    issue("R8 small file", 20, 4, 0, 990, 32, 0, 1000);
    issue("R8 base beyond file", 0, 4, 0, 1500, 4, 0, 1000);
    issue("R8 wide wrap", 4, 8, 1, 2000, 64, 40, 2048);
  endtask

  task automatic t_hold;
    int held;
    issue("R10 setup", 7, 4, 0, 200, 16, 0, 2048);
    held = int'(pidx_o);
    drive(1, 4, 0, 300, 0, 0, 0);
    @(negedge clk_i);
    chk("R10 pidx held", int'(pidx_o), held);
    chk("R10 err held",  int'(err_o), 0);
  endtask

  task automatic t_back2back;
    int e0, p0, e1, p1;
    model(2, 4, 0, 50, 8, 0, 2048, e0, p0);
    model(6, 8, 1, 50, 30, 10, 2048, e1, p1);
    @(negedge clk_i);
    drive(2, 4, 0, 50, 8, 0, 2048);
    req_valid_i = 1'b1;
    @(negedge clk_i);
    chk("R1 b2b first valid", int'(rsp_valid_o), 1);
    chk("R1 b2b first pidx",  int'(pidx_o), p0);
    drive(6, 8, 1, 50, 30, 10, 2048);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk("R1 b2b second valid", int'(rsp_valid_o), 1);
    chk("R3 b2b second pidx",  int'(pidx_o), p1);
    chk("R3 b2b second err",   int'(err_o), e1);
    @(negedge clk_i);
    chk("R1 b2b then low", int'(rsp_valid_o), 0);
  endtask

  initial begin
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_flat();
    t_mode_gate();
    t_wide();
    t_errors();
    t_wrap();
    t_hold();
    t_back2back();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule